// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a 32-bit interval timer that counts upward from its present counter value toward a programmable terminal value. It advances by one on every system clock while it is enabled. When the count equals the terminal value it raises a one-cycle interrupt pulse.

A single control bit picks what happens after a match. In periodic mode the count restarts from zero with no lost cycle. In one-shot mode hardware clears the enable bit and the count stays at the terminal value.

Software reaches three registers through a simple register port: a write strobe with an address, and a combinational read path selected by a second address. It can read the live count and can rewrite the count, the terminal value or the control word at any time, including while the timer runs.

Top module: `upcmp_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears to zero and `irq` goes low. After reset, all three registers read zero and the count does not move.
- R2: Register selects are: 0 = control (bit 0 run enable, bit 1 restart mode, upper bits read zero), 1 = terminal value, 2 = counter, 3 = reads zero and ignores writes. A write is visible on `rd_data` from the cycle after the strobe.
- R3: While run enable is set and there is no match, the counter rises by exactly one per clock. While run enable is clear, the counter holds.
- R4: A match is a cycle in which run enable is set and the counter equals the terminal value. On a match with restart mode clear, hardware clears run enable and the counter stays at the terminal value.
- R5: On a match with restart mode set, the counter is zero in the next cycle, run enable stays set, and counting continues from there.
- R6: `irq` is high in exactly the cycle after each match cycle and low in every other cycle.
- R7: A software write to the counter wins over any hardware update of the counter in the same cycle, including a match cycle.
- R8: A software write to the control register in a match cycle wins over the hardware clear of run enable.
- R9: A write to the terminal value takes effect at once: the next match compares against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the timer advances on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register select for the read |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| irq | output | 1 | One-cycle interrupt pulse following a match |

## Verification
The bench drives the timer to a counter write in the exact cycle of a match. A design that lets the hardware restart or hold win would show zero or the terminal value instead of the written count. It also rewrites control in a match cycle of a one-shot run, where a wrong priority would leave the timer stopped. The tests cover the restart-to-zero cycle in periodic mode, where an off-by-one design would either skip zero or stall a cycle at the terminal value, and so shift every later interrupt. They also lower the terminal value below the running count and raise it above the count mid-run, so that a design that latched the terminal value at start would fire at the wrong time.

// File: rtl/upcmp_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and control-bit positions for the
// up-counting compare timer. Assumes a 2-bit register select.
package upcmp_timer_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_TERM = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_RESTART_BIT = 1;
endpackage

// File: rtl/upcmp_ctrl_reg.sv
`timescale 1ns/1ps
// Module: control word of the timer (run enable and restart mode).
// Assumes: a software write wins over the hardware clear of run enable
// that a one-shot match requests in the same cycle.
module upcmp_ctrl_reg
    import upcmp_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              match_i,
    output logic              run_o,
    output logic              restart_o
);
    // Purpose: hold run/restart; software write first, then one-shot clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o     <= 1'b0;
            restart_o <= 1'b0;
        end else if (wr_ctrl_i) begin
            run_o     <= wdata_i[CTRL_RUN_BIT];
            restart_o <= wdata_i[CTRL_RESTART_BIT];
        end else if (match_i && !restart_o) begin
            run_o <= 1'b0;
        end
    end

    // R4: a one-shot match with no control write stops the timer.
    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !restart_o && !wr_ctrl_i) |=> !run_o);

    // R8: a control write in a match cycle sets run exactly as written.
    assert_ctrl_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_i |=> (run_o == $past(wdata_i[CTRL_RUN_BIT])));
endmodule

// File: rtl/upcmp_count_path.sv
`timescale 1ns/1ps
// Module: counter and terminal-value registers plus match detection.
// Assumes: run enable and restart mode come from the control register;
// a counter write wins over every hardware update in the same cycle.
module upcmp_count_path #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt_i,
    input  logic             wr_term_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             run_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] term_o,
    output logic             match_o
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    // Purpose: flag a cycle in which a running count sits on the terminal value.
    always_comb begin
        match_o = run_i && (cnt_o == term_o);
    end

    // Purpose: terminal-value register, loaded only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            term_o <= CNT_ZERO;
        else if (wr_term_i)
            term_o <= wdata_i;
    end

    // Purpose: counter; software write, then match handling, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= CNT_ZERO;
        else if (wr_cnt_i)
            cnt_o <= wdata_i;
        else if (match_o) begin
            if (restart_i)
                cnt_o <= CNT_ZERO;
        end else if (run_i)
            cnt_o <= cnt_o + CNT_ONE;
    end

    // R3: a running, unmatched, unwritten counter steps by one.
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !match_o && !wr_cnt_i) |=> (cnt_o == $past(cnt_o) + CNT_ONE));

    // R3: a stopped, unwritten counter holds.
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_cnt_i) |=> $stable(cnt_o));

    // R5: a periodic match restarts the count at zero.
    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && restart_i && !wr_cnt_i) |=> (cnt_o == CNT_ZERO));

    // R7: a counter write lands regardless of hardware activity.
    assert_cnt_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (cnt_o == $past(wdata_i)));
endmodule

// File: rtl/upcmp_irq_pulse.sv
`timescale 1ns/1ps
// Module: registers the match flag into the interrupt output.
// Assumes: the match flag is combinational; the pulse follows it by one cycle.
module upcmp_irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    output logic irq_o
);
    // Purpose: one-cycle interrupt for each match cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= match_i;
    end

    // R6: each match is followed by an interrupt cycle.
    assert_irq_after_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> irq_o);

    // R6: no interrupt without a preceding match.
    assert_no_spurious_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !match_i |=> !irq_o);
endmodule

// File: rtl/upcmp_timer.sv
`timescale 1ns/1ps
// Module: top of the up-counting compare timer. It decodes the register
// port, instantiates the control, count and interrupt stages, and muxes
// read data. Assumes: single-cycle writes, combinational reads.
module upcmp_timer
    import upcmp_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int CTRL_PAD = CNT_W - 2;

    logic             wr_ctrl, wr_term, wr_cnt;
    logic             run, restart, match;
    logic [CNT_W-1:0] cnt, term;

    // Purpose: decode the write strobe into per-register loads.
    always_comb begin
        wr_ctrl = wr_en && (reg_sel_e'(wr_addr) == SEL_CTRL);
        wr_term = wr_en && (reg_sel_e'(wr_addr) == SEL_TERM);
        wr_cnt  = wr_en && (reg_sel_e'(wr_addr) == SEL_CNT);
    end

    upcmp_ctrl_reg #(.DATA_W(CNT_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl_i (wr_ctrl),
        .wdata_i   (wr_data),
        .match_i   (match),
        .run_o     (run),
        .restart_o (restart)
    );

    upcmp_count_path #(.CNT_W(CNT_W)) count_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cnt_i  (wr_cnt),
        .wr_term_i (wr_term),
        .wdata_i   (wr_data),
        .run_i     (run),
        .restart_i (restart),
        .cnt_o     (cnt),
        .term_o    (term),
        .match_o   (match)
    );

    upcmp_irq_pulse irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match),
        .irq_o   (irq)
    );

    // Purpose: select the register shown on the read port.
    always_comb begin
        case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = {{CTRL_PAD{1'b0}}, restart, run};
            SEL_TERM: rd_data = term;
            SEL_CNT:  rd_data = cnt;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: tb/upcmp_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped each clock and compared with
// the read port and interrupt every cycle, plus fixed-value spot checks.
module upcmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd2;
    logic [31:0] rd_data;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    string req = "R1";

    // reference model state
    logic [31:0] m_cnt = 0, m_term = 0;
    bit m_run = 0, m_rst_mode = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    upcmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return {30'd0, m_rst_mode, m_run};
            2'd1: return m_term;
            2'd2: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", r, act, exp, $time);
        end
    endtask

    // one clock: advance model with the inputs present at the edge, then compare
    task automatic tick();
        bit hit;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_term = 0; m_run = 0; m_rst_mode = 0; m_irq = 0;
        end else begin
            hit = m_run && (m_cnt == m_term);
            m_irq = hit;
            if (wr_en && wr_addr == 2'd2) m_cnt = wr_data;
            else if (hit) begin
                if (m_rst_mode) m_cnt = 0;
            end else if (m_run) m_cnt = m_cnt + 1;
            if (wr_en && wr_addr == 2'd0) begin
                m_run = wr_data[0]; m_rst_mode = wr_data[1];
            end else if (hit && !m_rst_mode) m_run = 0;
            if (wr_en && wr_addr == 2'd1) m_term = wr_data;
        end
        #1;
        check({req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        check({req, " rd_data"}, rd_data, model_read(rd_addr));
    endtask

    task automatic write(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic peek(input string r, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a; #0.5;
        check(r, rd_data, exp);
        rd_addr = 2'd2;
    endtask

    initial begin
        // R1: reset state
        req = "R1";
        run(3);
        rst_n = 1'b1;
        run(2);
        peek("R1 ctrl", 2'd0, 32'd0);
        peek("R1 term", 2'd1, 32'd0);
        peek("R1 cnt", 2'd2, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2: register map, reserved select
        req = "R2";
        write(2'd3, 32'hFFFF_FFFF);
        peek("R2 reserved", 2'd3, 32'd0);
        write(2'd1, 32'd5);
        peek("R2 term", 2'd1, 32'd5);
        write(2'd0, 32'hFFFF_FFFC);
        peek("R2 ctrl pad", 2'd0, 32'd0);

        // R3/R4/R6: one-shot to 5 from 0
        req = "R4";
        write(2'd0, 32'h1);
        run(10);
        peek("R4 holds at term", 2'd2, 32'd5);
        peek("R4 run cleared", 2'd0, 32'd0);

        // R3: stopped counter holds
        req = "R3";
        run(4);
        peek("R3 stopped hold", 2'd2, 32'd5);
        write(2'd2, 32'd10);
        write(2'd1, 32'd14);
        write(2'd0, 32'h1);
        run(2);
        peek("R3 step", 2'd2, 32'd12);
        write(2'd0, 32'h0);
        run(3);
        peek("R3 disable hold", 2'd2, 32'd13);

        // R5/R6: periodic, terminal 3
        req = "R5";
        write(2'd2, 32'd0);
        write(2'd1, 32'd3);
        write(2'd0, 32'h3);
        run(14);
        peek("R5 still running", 2'd0, 32'd3);

        // R9: lower the terminal value below the count, then raise it
        req = "R9";
        write(2'd1, 32'd1000);
        run(5);
        write(2'd1, 32'd2);
        run(6);
        write(2'd2, 32'd0);
        write(2'd1, 32'd6);
        run(20);

        // R7: counter write in a match cycle
        req = "R7";
        while (!(m_run && m_cnt == m_term)) tick();
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd100;
        tick();
        wr_en = 1'b0;
        check("R7 irq still pulses", {31'd0, irq}, 32'd1);
        peek("R7 write wins", 2'd2, 32'd100);
        write(2'd2, 32'd0);

        // R8: control write in a one-shot match cycle
        req = "R8";
        write(2'd0, 32'h1);
        while (!(m_run && m_cnt == m_term)) tick();
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1;
        tick();
        wr_en = 1'b0;
        peek("R8 run kept", 2'd0, 32'd1);
        run(4);

        // R6: interrupt count over a periodic window
        req = "R6";
        begin
            int pulses = 0;
            write(2'd2, 32'd0);
            write(2'd1, 32'd4);
            write(2'd0, 32'h3);
            for (int i = 0; i < 25; i++) begin
                tick();
                if (irq) pulses++;
            end
            check("R6 pulses in 25 cycles", pulses, 32'd5);
        end

        // R1: reset mid-run
        req = "R1";
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        run(3);
        peek("R1 after reset cnt", 2'd2, 32'd0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule